// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a memory-mapped interval timer. A down-counter steps once per prescaled tick. Its tick comes from one of three clock-enable inputs supplied by the surrounding clock logic: main, fast or slow. When the counter reaches zero it either reloads from a programmable load value or wraps to the all-ones value. A separate compare register sets a sticky status flag when the counter steps onto it, and that flag can drive a level interrupt.

Software reaches five word-addressed registers through a simple strobe bus. The bus has a write strobe, a read strobe, a word offset and 32-bit data, and read data is returned in the same cycle as the read strobe. A self-clearing soft-reset bit in the control word returns the timer to a known state. This reset leaves the enable, start-mode and low-power configuration bits as they were written.

Top module: `periodic_irq_timer`

## Requirements
- R1: Word offsets are 0 control, 1 status, 2 load, 3 compare and 4 live count (read-only). Reads of offsets 5 to 7 return zero. Writes to offsets 4 to 7 change nothing. After hard reset, control, status, compare and count read zero and load reads 0xFFFFFFFF.
- R2: A control write stores only bits 25:0. The bit layout is: enable bit 0, start-mode bit 1, compare-interrupt-enable bit 2, reload bit 3, overwrite bit 4, soft-reset bit 5, prescale divisor bits 17:6, clock source bits 19:18, debug/wait/doze/stop hold bits 23:20, and spare bits 25:24.
- R3: The clock source field selects the tick input: 00 none, 01 main, 10 fast, 11 slow. Pulses on the other inputs have no effect.
- R4: The counter steps once every divisor+1 pulses of the selected input. The pulse phase restarts from zero whenever the timer is disabled or the source is 00.
- R5: Each step lowers the count by one. In reload mode, a step taken from zero loads the load value.
- R6: With the reload bit clear, a step taken from zero gives 0xFFFFFFFF, and the load value is not used.
- R7: A control write that raises enable with start-mode set loads the count with the load value (reload set) or 0xFFFFFFFF (reload clear). With start-mode clear, the count is kept.
- R8: A load write replaces the count in the same cycle when the overwrite bit is set. Otherwise the count is untouched and the new value is used at the next reload.
- R9: Status bit 0 sets in the cycle a step moves the count onto the compare value. Writing 1 to it clears it, and writing 0 leaves it. A step that hits the compare value in the same cycle as a clear leaves the flag set.
- R10: The interrupt output is high exactly while the flag, the compare-interrupt-enable bit and the enable bit are all set.
- R11: With enable clear, the count holds and no compare event occurs.
- R12: A control write with the soft-reset bit set stores only bits 0, 1 and 23:20 of the written value. It clears status, compare and count, and sets load to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_main_en | input | 1 | Main clock enable pulse |
| src_fast_en | input | 1 | Fast clock enable pulse |
| src_slow_en | input | 1 | Slow clock enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- Each counter step is exactly one down-step, a reload or a wrap.
- The count stays still when neither a step nor a bus load is applied.
- A compare hit only comes with a step, and it leaves the flag set even against a clear.
- The flag holds until it is cleared.
- The prescaler never fires on two adjacent pulses when the divisor is non-zero.

Only the bench's scenarios can show the register encodings and the divisor arithmetic across every source. The same holds for the start-mode and overwrite choices, for how the interrupt is gated, and for which bits survive a soft reset.

// File: rtl/pit_pkg.sv
// Package: shared constants and types for the periodic interrupt timer.
// Assumes a 32-bit register bus and a 3-bit word offset.
package pit_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 12;

    // Control word bit positions
    localparam int B_EN    = 0;
    localparam int B_START = 1;
    localparam int B_CIE   = 2;
    localparam int B_RLD   = 3;
    localparam int B_OW    = 4;
    localparam int B_SWR   = 5;
    localparam int B_PRE   = 6;
    localparam int B_SRC   = B_PRE + PRE_W;

    localparam logic [BUS_W-1:0] CTRL_MASK = 32'h03FF_FFFF;
    localparam logic [BUS_W-1:0] KEEP_MASK = 32'h00F0_0003;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_LOAD  = 3'd2,
        REG_CMP   = 3'd3,
        REG_COUNT = 3'd4
    } reg_off_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_FAST = 2'b10,
        SRC_SLOW = 2'b11
    } src_sel_e;
endpackage

// File: rtl/pit_regs.sv
// Module: register file and bus decode for the periodic interrupt timer.
// Holds control, load, compare and the compare flag. It turns bus writes
// into start, overwrite and soft-reset pulses for the counter.
// Assumes at most one register is written per cycle.
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count_val,
    input  logic              cmp_hit,
    output logic [BUS_W-1:0]  ctrl_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              flag_o,
    output logic              start_o,
    output logic [CNT_W-1:0]  start_val_o,
    output logic              ow_o,
    output logic [CNT_W-1:0]  ow_val_o,
    output logic              srst_o,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic [BUS_W-1:0] ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;

    logic wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic [BUS_W-1:0] ctrl_wr_val;
    logic [BUS_W-1:0] ctrl_new;
    logic             swr_req;

    // Decode the write strobe into one per-register write enable.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
        wr_stat = bus_wr && (bus_addr == REG_STAT);
        wr_load = bus_wr && (bus_addr == REG_LOAD);
        wr_cmp  = bus_wr && (bus_addr == REG_CMP);
    end

    // Form the next control word; a soft reset keeps only the hold bits.
    always_comb begin
        ctrl_wr_val = bus_wdata & CTRL_MASK;
        swr_req     = wr_ctrl && ctrl_wr_val[B_SWR];
        ctrl_new    = swr_req ? (ctrl_wr_val & KEEP_MASK) : ctrl_wr_val;
    end

    // Derive the counter-side pulses from the bus writes.
    always_comb begin
        start_o     = wr_ctrl && !swr_req && !ctrl_q[B_EN]
                      && ctrl_new[B_EN] && ctrl_new[B_START];
        start_val_o = ctrl_new[B_RLD] ? load_q : {CNT_W{1'b1}};
        ow_o        = wr_load && ctrl_q[B_OW];
        ow_val_o    = bus_wdata[CNT_W-1:0];
        srst_o      = swr_req;
    end

    // Control, load and compare storage with soft-reset handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= {CNT_W{1'b1}};
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_new;
            if (swr_req) begin
                load_q <= {CNT_W{1'b1}};
                cmp_q  <= '0;
            end else begin
                if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
                if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Sticky compare flag: a hit wins over a write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag_q <= 1'b0;
        else if (swr_req)                     flag_q <= 1'b0;
        else if (cmp_hit)                     flag_q <= 1'b1;
        else if (wr_stat && bus_wdata[0])     flag_q <= 1'b0;
    end

    // Read mux, returning zero outside the map or without a strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                REG_CTRL:  bus_rdata = ctrl_q;
                REG_STAT:  bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
                REG_LOAD:  bus_rdata = BUS_W'(load_q);
                REG_CMP:   bus_rdata = BUS_W'(cmp_q);
                REG_COUNT: bus_rdata = BUS_W'(count_val);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;
    assign load_o = load_q;
    assign cmp_o  = cmp_q;
    assign flag_o = flag_q;

    // R9: a compare hit always leaves the flag set next cycle.
    assert_hit_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit && !swr_req |=> flag_q);

    // R9: the flag only drops on a write of 1 to status or a soft reset.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(wr_stat && bus_wdata[0]) && !swr_req |=> flag_q);

    // R12: soft reset leaves status, compare and load at their reset values.
    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        swr_req |=> (!flag_q && cmp_q == '0 && load_q == {CNT_W{1'b1}}));
endmodule

// File: rtl/pit_prescaler.sv
// Module: source selection and divide-by-(N+1) tick generation.
// Picks one clock-enable input and emits one tick every div+1 pulses.
// Assumes the enable inputs are single-cycle pulses synchronous to clk.
module pit_prescaler
    import pit_pkg::*;
#(
    parameter int DIV_W = PRE_W,
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       src,
    input  logic [N_SRC-1:0] pulses,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic             sel_pulse;
    logic             run;
    logic [DIV_W-1:0] phase_q;

    // Select the enable pulse named by the source field; 00 selects none.
    always_comb begin
        sel_pulse = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src == 2'(i + 1)) sel_pulse = pulses[i];
        end
    end

    // Run only when enabled with a real source; fire at the end of a phase.
    always_comb begin
        run  = enable && (src != SRC_OFF);
        tick = run && sel_pulse && (phase_q >= div);
    end

    // Phase counter; restarts whenever the timer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= '0;
        else if (!run)       phase_q <= '0;
        else if (sel_pulse)  phase_q <= (phase_q >= div) ? '0 : phase_q + 1'b1;
    end

    // R3: the off source never yields a tick.
    assert_off_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_OFF) |-> !tick);

    // R4: with a non-zero divisor, two ticks are never back to back.
    assert_divide_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (div != '0) && $stable(div) |=> !tick);
endmodule

// File: rtl/pit_counter.sv
// Module: the down-counter and its compare detector.
// Applies, in priority order, soft reset, enable-start load, bus overwrite
// and a prescaled step. Flags a compare hit only when a step lands on the
// compare value.
module pit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    input  logic             ow,
    input  logic [CNT_W-1:0] ow_val,
    input  logic             srst,
    output logic [CNT_W-1:0] count,
    output logic             cmp_hit
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] step_val;
    logic             step_ok;

    // Value after one step: decrement, reload or wrap.
    always_comb begin
        if (count_q == '0) step_val = reload_mode ? load_val : ALL_ONES;
        else               step_val = count_q - 1'b1;
        step_ok = tick && !srst && !start && !ow;
        cmp_hit = step_ok && (step_val == cmp_val);
    end

    // Count register update by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (srst)    count_q <= '0;
        else if (start)   count_q <= start_val;
        else if (ow)      count_q <= ow_val;
        else if (tick)    count_q <= step_val;
    end

    assign count = count_q;

    // R5: a step from a non-zero count lowers it by one.
    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok && count_q != '0 |=> count_q == $past(count_q) - 1'b1);

    // R5: a step from zero in reload mode takes the load value.
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok && count_q == '0 && reload_mode |=> count_q == $past(load_val));

    // R6: a step from zero in free-run mode wraps to all ones.
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok && count_q == '0 && !reload_mode |=> count_q == ALL_ONES);

    // R11: without a step or bus load the count holds.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !srst && !start && !ow |=> $stable(count_q));

    // R9: a compare hit requires a step in the same cycle.
    assert_hit_needs_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |-> tick);
endmodule

// File: rtl/periodic_irq_timer.sv
// Module: top of the periodic interrupt timer.
// Wires the register file, the prescaler and the counter together, and
// gates the interrupt. Assumes CNT_W is at most the 32-bit bus width.
module periodic_irq_timer
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_main_en,
    input  logic              src_fast_en,
    input  logic              src_slow_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int N_SRC = 3;

    logic [BUS_W-1:0] ctrl;
    logic [CNT_W-1:0] load_val, cmp_val, count, start_val, ow_val;
    logic             flag, start, ow, srst, tick, cmp_hit;
    logic [N_SRC-1:0] pulses;

    // Gather the clock-enable inputs in source-code order.
    assign pulses = {src_slow_en, src_fast_en, src_main_en};

    pit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .count_val   (count),
        .cmp_hit     (cmp_hit),
        .ctrl_o      (ctrl),
        .load_o      (load_val),
        .cmp_o       (cmp_val),
        .flag_o      (flag),
        .start_o     (start),
        .start_val_o (start_val),
        .ow_o        (ow),
        .ow_val_o    (ow_val),
        .srst_o      (srst),
        .bus_rdata   (bus_rdata)
    );

    pit_prescaler #(.DIV_W(PRE_W), .N_SRC(N_SRC)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctrl[B_EN]),
        .src    (ctrl[B_SRC +: 2]),
        .pulses (pulses),
        .div    (ctrl[B_PRE +: PRE_W]),
        .tick   (tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .reload_mode (ctrl[B_RLD]),
        .load_val    (load_val),
        .cmp_val     (cmp_val),
        .start       (start),
        .start_val   (start_val),
        .ow          (ow),
        .ow_val      (ow_val),
        .srst        (srst),
        .count       (count),
        .cmp_hit     (cmp_hit)
    );

    // Level interrupt gated by compare-interrupt-enable and timer enable.
    always_comb begin
        irq = flag && ctrl[B_CIE] && ctrl[B_EN];
    end

    // R10: clearing the timer enable drops the interrupt in the same cycle.
    assert_irq_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl[B_EN]) |-> !irq);
endmodule

// File: tb/tb_periodic_irq_timer.sv
module tb_periodic_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_main_en = 1'b0, src_fast_en = 1'b0, src_slow_en = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Control bits as laid out in R2
    localparam logic [31:0] C_EN = 32'h1, C_SM = 32'h2, C_CIE = 32'h4,
                            C_RLD = 32'h8, C_OW = 32'h10, C_SWR = 32'h20;
    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

    periodic_irq_timer dut (
        .clk(clk), .rst_n(rst_n),
        .src_main_en(src_main_en), .src_fast_en(src_fast_en), .src_slow_en(src_slow_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] cw(input int src, input int pre, input logic [31:0] fl);
        return fl | (32'(pre) << 6) | (32'(src) << 18);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // sel: 0 main, 1 fast, 2 slow
    task automatic pulse(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_main_en = (sel == 0); src_fast_en = (sel == 1); src_slow_en = (sel == 2);
        end
        @(negedge clk);
        src_main_en = 1'b0; src_fast_en = 1'b0; src_slow_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(0, v); chk("R1 ctrl reset", v, 0);
        rd(1, v); chk("R1 status reset", v, 0);
        rd(2, v); chk("R1 load reset", v, MAXV);
        rd(3, v); chk("R1 cmp reset", v, 0);
        rd(4, v); chk("R1 count reset", v, 0);
        chk("R10 irq reset", 32'(irq), 0);

        // R2 control mask
        wr(0, 32'hFFFF_FFDF);
        rd(0, v); chk("R2 ctrl mask", v, 32'h03FF_FFDF);
        wr(0, 0);

        // R3 source off: no counting
        wr(0, cw(0, 0, C_EN | C_SM));
        pulse(0, 2); pulse(1, 2); pulse(2, 2);
        rd(4, v); chk("R3 src off", v, MAXV);
        wr(0, 0);

        // R3/R4 sweep of source and divisor
        for (int s = 1; s <= 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                wr(0, cw(s, p, C_EN | C_SM));
                for (int o = 0; o < 3; o++) if (o != s - 1) pulse(o, 3);
                rd(4, v); chk("R3 other sources ignored", v, MAXV);
                pulse(s - 1, 7);
                rd(4, v); chk("R4 divide", v, MAXV - 32'(7 / (p + 1)));
                wr(0, 0);
            end
        end

        // R5 reload sweep, R7 start with reload
        wr(2, 3);
        wr(0, cw(1, 0, C_EN | C_SM | C_RLD));
        rd(4, v); chk("R7 start loads load value", v, 3);
        for (int k = 1; k <= 9; k++) begin
            pulse(0, 1);
            rd(4, v); chk("R5 reload sequence", v, 32'(3 - (k % 4)));
        end

        // R8 load without overwrite
        wr(2, 6);
        rd(4, v); chk("R8 no overwrite keeps count", v, 2);
        pulse(0, 2);
        rd(4, v); chk("R8 count reaches zero", v, 0);
        pulse(0, 1);
        rd(4, v); chk("R8 new load used at reload", v, 6);
        wr(0, cw(1, 0, C_EN | C_SM | C_RLD | C_OW));
        rd(4, v); chk("R7 no reload without rising enable", v, 6);
        wr(2, 10);
        rd(4, v); chk("R8 overwrite", v, 10);

        // R6 rollover, R7 start-mode clear keeps count
        wr(0, 0);
        wr(0, cw(1, 0, C_OW));
        wr(2, 2);
        wr(0, cw(1, 0, C_EN | C_OW));
        rd(4, v); chk("R7 start-mode clear keeps count", v, 2);
        pulse(0, 3);
        rd(4, v); chk("R6 wrap to all ones", v, MAXV);
        pulse(0, 1);
        rd(4, v); chk("R6 after wrap", v, MAXV - 1);

        // R11 disabled holds count
        wr(0, cw(1, 0, C_OW));
        pulse(0, 5);
        rd(4, v); chk("R11 hold when disabled", v, MAXV - 1);

        // R9/R10 compare
        wr(0, 0);
        wr(2, 5);
        wr(3, 3);
        wr(1, 1);
        rd(1, v); chk("R9 flag cleared", v, 0);
        wr(0, cw(1, 0, C_EN | C_SM | C_RLD | C_CIE));
        pulse(0, 1);
        rd(1, v); chk("R9 no flag before match", v, 0);
        chk("R10 irq low", 32'(irq), 0);
        pulse(0, 1);
        rd(1, v); chk("R9 flag on match", v, 1);
        chk("R10 irq high", 32'(irq), 1);
        pulse(0, 1);
        wr(1, 0);
        rd(1, v); chk("R9 write 0 keeps flag", v, 1);
        wr(1, 1);
        rd(1, v); chk("R9 write 1 clears", v, 0);
        chk("R10 irq low after clear", 32'(irq), 0);
        pulse(0, 4);
        rd(4, v); chk("R5 count before collision", v, 4);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1; bus_wdata = 1; src_main_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; src_main_en = 1'b0;
        rd(1, v); chk("R9 set wins over clear", v, 1);
        rd(4, v); chk("R9 count at compare", v, 3);
        wr(0, cw(1, 0, C_EN | C_RLD));
        chk("R10 irq masked by cie", 32'(irq), 0);
        wr(0, cw(1, 0, C_EN | C_RLD | C_CIE));
        chk("R10 irq unmasked", 32'(irq), 1);
        wr(0, cw(1, 0, C_RLD | C_CIE));
        chk("R10 irq off when disabled", 32'(irq), 0);
        rd(1, v); chk("R10 flag kept when disabled", v, 1);
        wr(1, 1);
        pulse(0, 4);
        rd(1, v); chk("R11 no compare when disabled", v, 0);
        rd(4, v); chk("R11 count held", v, 3);

        // R1 unmapped offsets
        wr(5, 32'h1234); wr(6, 32'h5678); wr(7, 32'h9ABC); wr(4, 32'h77);
        rd(5, v); chk("R1 read off 5", v, 0);
        rd(6, v); chk("R1 read off 6", v, 0);
        rd(7, v); chk("R1 read off 7", v, 0);
        rd(4, v); chk("R1 count read-only", v, 3);
        rd(0, v); chk("R1 ctrl untouched", v, cw(1, 0, C_RLD | C_CIE));
        rd(2, v); chk("R1 load untouched", v, 5);
        rd(3, v); chk("R1 cmp untouched", v, 3);

        // R12 soft reset
        wr(0, 0);
        wr(3, 2);
        wr(0, cw(1, 3, C_EN | C_SM | C_RLD | C_CIE) | 32'h00F0_0000);
        pulse(0, 12);
        rd(4, v); exp_cnt = 2; chk("R4 divide by four", v, exp_cnt);
        rd(1, v); chk("R12 flag set before reset", v, 1);
        wr(0, cw(1, 3, C_EN | C_SM | C_RLD | C_CIE | C_SWR) | 32'h00F0_0000);
        rd(0, v); chk("R12 ctrl keeps hold bits", v, 32'h00F0_0003);
        rd(1, v); chk("R12 status cleared", v, 0);
        rd(2, v); chk("R12 load all ones", v, MAXV);
        rd(3, v); chk("R12 cmp cleared", v, 0);
        rd(4, v); chk("R12 count cleared", v, 0);
        chk("R12 irq low", 32'(irq), 0);

        done = 1'b1;
        finish_run();
    end
endmodule